// File: doc/BRIEF.md
# Fan PWM Controller with Event Interrupts

This block drives a cooling fan from a single pulse-width output and reports fan-related events to a host through one level-high interrupt line. The host reaches its registers through a plain 32-bit word-addressed read/write port. The bus protocol wrapper sits outside the block. Temperature sensing and tach evaluation also sit outside it. The block receives three strobes: a temperature rise, a tach error, and a completed tach measurement, which comes with its value.

The host first releases the core by setting a run bit, because the core stays idle until then. It then unmasks the events it wants. From that point it can program the high time of the output in clock cycles. The frame length is fixed by a parameter and can be read back but not written. Duty can change in two ways. A host write changes it directly. A temperature-rise strobe makes the core raise the duty to full on its own and flag that request at once. In both cases the block waits a settling interval, given in clock cycles, before it reports that the duty has changed. This gives the fan time to reach its new speed.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After `rst` the run bit (word 0x20, bit 0) reads 0, the mask (word 0x10) reads 0xF, pending (word 0x11) reads 0, the width (word 0x21) reads 0, and both `pwm_out` and `irq` are low.
- R2: While the run bit is 0, `pwm_out` stays low and no strobe or settling expiry sets a pending bit.
- R3: While running, `pwm_out` is high for exactly min(width, PWM_PERIOD) cycles in every window of PWM_PERIOD consecutive cycles. A width of 0 gives a constant low output, and a width at or above the period gives a constant high output.
- R4: Word 0x30 always reads PWM_PERIOD, and writes to it are ignored.
- R5: A host width write while running sets pending bit 0 (duty changed) SETTLE_CYCLES cycles later, within a few cycles, and not before.
- R6: A temperature-rise strobe while running sets pending bit 2 on the next cycle and sets the width to PWM_PERIOD. It then sets pending bit 0 after the settling interval.
- R7: A measurement strobe stores its value in word 0x31 and sets pending bit 3. A tach-error strobe sets pending bit 1.
- R8: Writing pending clears each bit written as 1 and leaves the others alone. An event that arrives in the same cycle as the clear of its bit leaves the bit set.
- R9: `irq` is high, one cycle after the state changes, exactly when some pending bit has a mask bit of 0. A mask bit of 1 disables its event.
- R10: The source register (word 0x12) reads pending AND NOT mask.
- R11: The tach expected period (word 0x22) and tolerance (word 0x23) registers read back the last value written. Word 0x32 (temperature) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, valid one cycle after the address |
| temp_inc_stb | input | 1 | Temperature-rise event, one cycle |
| tach_err_stb | input | 1 | Tach error event, one cycle |
| tach_meas_stb | input | 1 | New tach measurement event, one cycle |
| tach_meas_val | input | DATA_W | Measurement value captured with its strobe |
| pwm_out | output | 1 | Fan drive output |
| irq | output | 1 | Level-high interrupt |

## Verification
A wrong frame counter or a wrong width compare shows up at `pwm_out` within one frame. It appears as a high-cycle count that differs from min(width, period). A settling timer that fires early, fires late, or never reloads shows up in pending bit 0 around SETTLE_CYCLES after the triggering write or strobe. Mask and pending state that is wrong reaches `irq` and the source register one cycle later. A pending bit that drops without a host write is caught the cycle it falls.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int N_EV = 4;
  localparam int EV_DUTY     = 0;
  localparam int EV_TACH_ERR = 1;
  localparam int EV_TEMP     = 2;
  localparam int EV_MEAS     = 3;

  localparam int A_MASK   = 'h10;
  localparam int A_PEND   = 'h11;
  localparam int A_SRC    = 'h12;
  localparam int A_RUN    = 'h20;
  localparam int A_WIDTH  = 'h21;
  localparam int A_TPER   = 'h22;
  localparam int A_TTOL   = 'h23;
  localparam int A_PERIOD = 'h30;
  localparam int A_MEAS   = 'h31;
  localparam int A_TEMP   = 'h32;
endpackage

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DATA_W     = 32,
  parameter int PWM_PERIOD = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] width,
  output logic              pwm_o
);
  localparam int CNT_W = (PWM_PERIOD > 1) ? $clog2(PWM_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWM_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      pwm_o <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      pwm_o <= DATA_W'(cnt_q) < width;
    end
  end
endmodule

// File: rtl/fan_settle_timer.sv
module fan_settle_timer #(
  parameter int SETTLE_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  output logic done
);
  localparam int TW = $clog2(SETTLE_CYCLES + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= (cnt_q == TW'(1)) && !start;
      if (start)
        cnt_q <= TW'(SETTLE_CYCLES);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fan_irq_ctrl.sv
module fan_irq_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         wr_mask,
  input  logic         wr_pend,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] clr;

  assign clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_mask)
        mask_o <= wdata;
      pend_o <= (pend_o & ~clr) | set_i;
      irq_o  <= |(pend_o & ~mask_o);
    end
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int PWM_PERIOD    = 1000,
  parameter int SETTLE_CYCLES = 500_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              temp_inc_stb,
  input  logic              tach_err_stb,
  input  logic              tach_meas_stb,
  input  logic [DATA_W-1:0] tach_meas_val,
  output logic              pwm_out,
  output logic              irq
);
  localparam logic [DATA_W-1:0] PERIOD_V = DATA_W'(PWM_PERIOD);

  logic              run_q;
  logic [DATA_W-1:0] width_q, tper_q, ttol_q, meas_q;
  logic [N_EV-1:0]   mask, pend, ev_set;
  logic              settle_done, width_wr, settle_start;
  logic              wr_mask, wr_pend;

  assign width_wr     = reg_we && (reg_addr == ADDR_W'(A_WIDTH));
  assign wr_mask      = reg_we && (reg_addr == ADDR_W'(A_MASK));
  assign wr_pend      = reg_we && (reg_addr == ADDR_W'(A_PEND));
  assign settle_start = run_q && (width_wr || temp_inc_stb);

  always_comb begin
    ev_set              = '0;
    ev_set[EV_DUTY]     = run_q && settle_done;
    ev_set[EV_TACH_ERR] = run_q && tach_err_stb;
    ev_set[EV_TEMP]     = run_q && temp_inc_stb;
    ev_set[EV_MEAS]     = run_q && tach_meas_stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      width_q <= '0;
      tper_q  <= '0;
      ttol_q  <= '0;
      meas_q  <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(A_RUN))  run_q  <= reg_wdata[0];
      if (reg_we && reg_addr == ADDR_W'(A_TPER)) tper_q <= reg_wdata;
      if (reg_we && reg_addr == ADDR_W'(A_TTOL)) ttol_q <= reg_wdata;
      if (run_q && temp_inc_stb)
        width_q <= PERIOD_V;
      else if (width_wr)
        width_q <= reg_wdata;
      if (run_q && tach_meas_stb)
        meas_q <= tach_meas_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        ADDR_W'(A_MASK):   reg_rdata <= DATA_W'(mask);
        ADDR_W'(A_PEND):   reg_rdata <= DATA_W'(pend);
        ADDR_W'(A_SRC):    reg_rdata <= DATA_W'(pend & ~mask);
        ADDR_W'(A_RUN):    reg_rdata <= DATA_W'(run_q);
        ADDR_W'(A_WIDTH):  reg_rdata <= width_q;
        ADDR_W'(A_TPER):   reg_rdata <= tper_q;
        ADDR_W'(A_TTOL):   reg_rdata <= ttol_q;
        ADDR_W'(A_PERIOD): reg_rdata <= PERIOD_V;
        ADDR_W'(A_MEAS):   reg_rdata <= meas_q;
        default:           reg_rdata <= '0;
      endcase
    end
  end

  fan_pwm_gen #(.DATA_W(DATA_W), .PWM_PERIOD(PWM_PERIOD)) u_gen (
    .clk(clk), .rst(rst), .run(run_q), .width(width_q), .pwm_o(pwm_out)
  );

  fan_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .run(run_q), .start(settle_start), .done(settle_done)
  );

  fan_irq_ctrl #(.N(N_EV)) u_irq (
    .clk(clk), .rst(rst), .set_i(ev_set), .wr_mask(wr_mask), .wr_pend(wr_pend),
    .wdata(reg_wdata[N_EV-1:0]), .mask_o(mask), .pend_o(pend), .irq_o(irq)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int N      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              run,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      mask,
  input logic              pwm_out,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(fan_pwm_pkg::A_PEND);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!irq && !pwm_out));

  p_halt_low_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_out);

  p_halt_no_new_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !rst) |=> ((pend & ~$past(pend)) == '0));

  p_pend_clear_only_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(pend) & ~pend) != '0)) |-> $past(reg_we && reg_addr == PEND_A));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (((pend & ~mask) == '0) && !rst) |=> !irq);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.ADDR_W(ADDR_W), .N(fan_pwm_pkg::N_EV)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .run(run_q),
  .pend(pend), .mask(mask), .pwm_out(pwm_out), .irq(irq)
);

// File: tb/fan_pwm_ctrl_tb.sv
module fan_pwm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 20;
  localparam int S = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        temp_inc_stb = 1'b0, tach_err_stb = 1'b0, tach_meas_stb = 1'b0;
  logic [31:0] tach_meas_val = '0;
  logic        pwm_out, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_pwm_ctrl #(.PWM_PERIOD(P), .SETTLE_CYCLES(S)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_inc_stb(temp_inc_stb),
    .tach_err_stb(tach_err_stb), .tach_meas_stb(tach_meas_stb),
    .tach_meas_val(tach_meas_val), .pwm_out(pwm_out), .irq(irq)
  );

  function automatic int exp_high(input int w);
    return (w > P) ? P : w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 8'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: temp_inc_stb = 1'b1;
      1: tach_err_stb = 1'b1;
      default: tach_meas_stb = 1'b1;
    endcase
    @(negedge clk);
    temp_inc_stb = 1'b0; tach_err_stb = 1'b0; tach_meas_stb = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    repeat (P) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_out", 32'(pwm_out), 0);
    check("R1 irq", 32'(irq), 0);
    rd('h20, d); check("R1 run", d, 0);
    rd('h10, d); check("R1 mask", d, 32'hF);
    rd('h11, d); check("R1 pend", d, 0);
    rd('h21, d); check("R1 width", d, 0);

    // R2 halted core: events ignored, output low
    wr('h10, 0);
    wr('h21, P);
    pulse(0); pulse(1); pulse(2);
    repeat (S + 5) @(negedge clk);
    rd('h11, d); check("R2 no pending while halted", d, 0);
    count_high(n); check("R2 output low while halted", n, 0);
    check("R2 irq low", 32'(irq), 0);

    // release; width P -> constant high (R3)
    wr('h20, 1);
    repeat (3) @(negedge clk);
    count_high(n); check("R3 width=period const high", n, P);

    // R4 read-only period
    rd('h30, d); check("R4 period", d, P);
    wr('h30, 5);
    rd('h30, d); check("R4 period write ignored", d, P);

    // R11 storage registers
    for (int i = 0; i < 3; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      wr('h22, a); wr('h23, b);
      rd('h22, d); check("R11 tach period", d, a);
      rd('h23, d); check("R11 tach tolerance", d, b);
    end
    rd('h32, d); check("R11 temperature reads 0", d, 0);

    // R5 settle delay after software write
    wr('h11, 32'hF);
    wr('h21, 7);
    repeat (S - 12) @(negedge clk);
    rd('h11, d); check("R5 duty event not early", d & 1, 0);
    repeat (16) @(negedge clk);
    rd('h11, d); check("R5 duty event after settle", d & 1, 1);
    check("R9 irq on unmasked pending", 32'(irq), 1);
    count_high(n); check("R3 width=7", n, 7);
    wr('h11, 1);
    rd('h11, d); check("R8 write-1 clears", d, 0);
    @(negedge clk);
    check("R9 irq drops", 32'(irq), 0);

    // R9/R10 masking
    wr('h10, 32'h2);
    pulse(1);
    repeat (3) @(negedge clk);
    rd('h11, d); check("R7 tach error pending", d, 2);
    check("R9 masked no irq", 32'(irq), 0);
    rd('h12, d); check("R10 source masked", d, 0);
    wr('h10, 0);
    repeat (3) @(negedge clk);
    check("R9 unmask raises irq", 32'(irq), 1);
    rd('h12, d); check("R10 source unmasked", d, 2);
    wr('h11, 0);
    rd('h11, d); check("R8 write 0 keeps bits", d, 2);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h11; reg_wdata = 32'h2; tach_err_stb = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tach_err_stb = 1'b0;
    rd('h11, d); check("R8 set wins over clear", d, 2);
    wr('h11, 32'hF);

    // R7 measurement capture
    for (int i = 0; i < 2; i++) begin
      logic [31:0] v;
      v = $urandom;
      @(negedge clk); tach_meas_val = v;
      pulse(2);
      rd('h31, d); check("R7 measurement value", d, v);
      rd('h11, d); check("R7 measurement pending", d, 8);
      wr('h11, 32'hF);
    end

    // R6 hardware request
    wr('h21, 3);
    repeat (S + 5) @(negedge clk);
    wr('h11, 32'hF);
    pulse(0);
    rd('h11, d); check("R6 temp pending only", d, 4);
    rd('h21, d); check("R6 width forced to period", d, P);
    repeat (S + 5) @(negedge clk);
    rd('h11, d); check("R6 duty event after settle", d, 5);
    count_high(n); check("R6 full drive", n, P);
    wr('h11, 32'hF);

    // R3 random and directed widths
    for (int i = 0; i < 8; i++) begin
      int w;
      case (i)
        0: w = 0;
        1: w = P;
        2: w = P + 3;
        3: w = 1;
        default: w = int'($urandom % (P + 6));
      endcase
      wr('h21, 32'(w));
      repeat (P + 3) @(negedge clk);
      count_high(n); check("R3 high cycles per frame", n, exp_high(w));
    end

    // R2 halt again
    wr('h20, 0);
    repeat (2) @(negedge clk);
    count_high(n); check("R2 halt forces low", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule